// File: doc/BRIEF.md
# Mode-Banked Integer Register File with Shadow Registers

This block holds the integer register state of a 64-bit core: a main array of 32 registers, two combinational read ports and one write port. When the core runs its privileged firmware mode, a handful of register numbers stop reaching the main array. Registers 8 to 14 and the single register 25 are redirected to a private bank of eight shadow registers. Firmware can therefore use those registers as scratch space without saving the interrupted program's values first.

Each access is routed by the mode flag present in the same cycle. A register number that is not banked reaches the main array in both modes. Register 31 is a hard zero.

The ports are plain control and data pins, with no valid/ready handshake. A read port returns data in the same cycle for any index. The write port accepts a write on every clock edge, so neither side ever sees back-pressure.

Top module: `priv_shadow_regfile`

## Requirements
- R1: While `shadow_mode` is 1, register numbers 8 through 14 read and write shadow entries 0 through 6 (entry = number − 8). The main-array registers 8 to 14 keep their values.
- R2: While `shadow_mode` is 1, register number 25 reads and writes shadow entry 7. Main-array register 25 keeps its value.
- R3: While `shadow_mode` is 0, every register number reaches the main array, and no shadow entry is written.
- R4: While `shadow_mode` is 1, register numbers 0–7, 15–24 and 26–30 reach the same main-array registers as in the other mode.
- R5: Register 31 reads as zero on both ports in both modes, and a write to it changes nothing.
- R6: A write lands on the rising clock edge. A read of the same register in the write's cycle returns the previous value, and a read in the next cycle returns the new one.
- R7: The two read ports are independent. Both may address any register, including the same one, in the same cycle.
- R8: Routing uses the mode flag of the cycle in which the access happens. An access right after a mode change uses the new mode.
- R9: A synchronous active-high reset clears every main and shadow register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| shadow_mode | input | 1 | 1 = privileged firmware mode (banked registers routed to the shadow bank) |
| rd_idx_a | input | 5 | Read port A register number |
| rd_data_a | output | 64 | Read port A data (combinational) |
| rd_idx_b | input | 5 | Read port B register number |
| rd_data_b | output | 64 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | 64 | Write data |

## Verification
The bench loads different values into the same register number in the two modes. It then reads that number in both modes, so a wrong routing decode shows up at the outputs. For example, a design that aliased the shadow entries onto the main array would return the last write for both modes. A design that routed 7, 15, 24 or 26 into the shadow bank would lose the value across a mode change. An edge-sensitive mode latch would serve the first access after a switch from the wrong bank. The bench also writes register 31 and reads the written register in the write's cycle. A design that stored register 31 would return nonzero, and one that forwarded the write would return the new value too early.

// File: rtl/shreg_pkg.sv
`timescale 1ns/1ps
package shreg_pkg;
  // Destination chosen for one register access
  typedef enum logic [1:0] {
    BANK_MAIN   = 2'd0,
    BANK_SHADOW = 2'd1,
    BANK_ZERO   = 2'd2
  } bank_sel_e;
endpackage

// File: rtl/shreg_route.sv
`timescale 1ns/1ps
// Decodes one register number into a bank and an entry, given the mode flag.
module shreg_route
  import shreg_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int SH_W     = 3,
  parameter int RANGE_LO = 8,
  parameter int RANGE_HI = 14,
  parameter int LONE_REG = 25,
  parameter int ZERO_REG = 31
) (
  input  logic             shadow_mode,
  input  logic [IDX_W-1:0] idx,
  output bank_sel_e        bank,
  output logic [SH_W-1:0]  sidx
);
  localparam logic [IDX_W-1:0] LO_IDX   = IDX_W'(RANGE_LO);
  localparam logic [IDX_W-1:0] HI_IDX   = IDX_W'(RANGE_HI);
  localparam logic [IDX_W-1:0] LONE_IDX = IDX_W'(LONE_REG);
  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(ZERO_REG);
  localparam logic [SH_W-1:0]  LONE_SH  = SH_W'(RANGE_HI - RANGE_LO + 1);

  logic in_range;
  logic is_lone;

  always_comb begin
    in_range = (idx >= LO_IDX) && (idx <= HI_IDX);
    is_lone  = (idx == LONE_IDX);
    bank     = BANK_MAIN;
    sidx     = '0;
    if (idx == ZERO_IDX) begin
      bank = BANK_ZERO;
    end else if (shadow_mode && in_range) begin
      bank = BANK_SHADOW;
      sidx = SH_W'(idx - LO_IDX);
    end else if (shadow_mode && is_lone) begin
      bank = BANK_SHADOW;
      sidx = LONE_SH;
    end
  end
endmodule

// File: rtl/shreg_bank.sv
`timescale 1ns/1ps
// Flop array: one write port, two combinational read ports, synchronous clear.
module shreg_bank #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 64,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (rst) begin
        cells[e] <= '0;
      end else if (we && (waddr == AW'(e))) begin
        cells[e] <= wdata;
      end
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

  // R6: with no write, an entry read twice in a row returns the same data
  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !we |=> ((raddr_a != $past(raddr_a)) || $stable(rdata_a)));
endmodule

// File: rtl/priv_shadow_regfile.sv
`timescale 1ns/1ps
module priv_shadow_regfile
  import shreg_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  parameter int RANGE_LO = 8,
  parameter int RANGE_HI = 14,
  parameter int LONE_REG = 25
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shadow_mode,
  input  logic [$clog2(NUM_REGS)-1:0] rd_idx_a,
  output logic [DATA_W-1:0]           rd_data_a,
  input  logic [$clog2(NUM_REGS)-1:0] rd_idx_b,
  output logic [DATA_W-1:0]           rd_data_b,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
  input  logic [DATA_W-1:0]           wr_data
);
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int SHADOW_N = RANGE_HI - RANGE_LO + 2;
  localparam int SH_W     = $clog2(SHADOW_N);
  localparam int ZERO_REG = NUM_REGS - 1;
  localparam int N_ACC    = 3;  // read A, read B, write
  localparam int N_RD     = 2;
  localparam logic [IDX_W-1:0] LO_IDX   = IDX_W'(RANGE_LO);
  localparam logic [IDX_W-1:0] HI_IDX   = IDX_W'(RANGE_HI);
  localparam logic [IDX_W-1:0] LONE_IDX = IDX_W'(LONE_REG);
  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(ZERO_REG);

  logic [IDX_W-1:0]  acc_idx  [N_ACC];
  bank_sel_e         acc_bank [N_ACC];
  logic [SH_W-1:0]   acc_sidx [N_ACC];
  logic [DATA_W-1:0] main_rd  [N_RD];
  logic [DATA_W-1:0] sh_rd    [N_RD];
  logic [DATA_W-1:0] port_rd  [N_RD];
  logic              mn_we;
  logic              sh_we;

  assign acc_idx[0] = rd_idx_a;
  assign acc_idx[1] = rd_idx_b;
  assign acc_idx[2] = wr_idx;

  for (genvar p = 0; p < N_ACC; p++) begin : g_route
    shreg_route #(
      .IDX_W(IDX_W), .SH_W(SH_W), .RANGE_LO(RANGE_LO),
      .RANGE_HI(RANGE_HI), .LONE_REG(LONE_REG), .ZERO_REG(ZERO_REG)
    ) i_route (
      .shadow_mode(shadow_mode),
      .idx        (acc_idx[p]),
      .bank       (acc_bank[p]),
      .sidx       (acc_sidx[p])
    );
  end

  assign mn_we = wr_en && (acc_bank[2] == BANK_MAIN);
  assign sh_we = wr_en && (acc_bank[2] == BANK_SHADOW);

  shreg_bank #(.DEPTH(NUM_REGS), .DATA_W(DATA_W), .AW(IDX_W)) i_main (
    .clk(clk), .rst(rst), .we(mn_we), .waddr(wr_idx), .wdata(wr_data),
    .raddr_a(rd_idx_a), .raddr_b(rd_idx_b),
    .rdata_a(main_rd[0]), .rdata_b(main_rd[1])
  );

  shreg_bank #(.DEPTH(SHADOW_N), .DATA_W(DATA_W), .AW(SH_W)) i_shadow (
    .clk(clk), .rst(rst), .we(sh_we), .waddr(acc_sidx[2]), .wdata(wr_data),
    .raddr_a(acc_sidx[0]), .raddr_b(acc_sidx[1]),
    .rdata_a(sh_rd[0]), .rdata_b(sh_rd[1])
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_rdmux
    always_comb begin
      unique case (acc_bank[p])
        BANK_MAIN:   port_rd[p] = main_rd[p];
        BANK_SHADOW: port_rd[p] = sh_rd[p];
        default:     port_rd[p] = '0;
      endcase
    end
  end

  assign rd_data_a = port_rd[0];
  assign rd_data_b = port_rd[1];

  // R1: banked range writes go to the shadow bank only
  assert_range_map_R1: assert property (@(posedge clk) disable iff (rst)
    (shadow_mode && wr_en && wr_idx >= LO_IDX && wr_idx <= HI_IDX) |-> (sh_we && !mn_we));
  // R2: the isolated banked register writes the shadow bank only
  assert_lone_map_R2: assert property (@(posedge clk) disable iff (rst)
    (shadow_mode && wr_en && wr_idx == LONE_IDX) |-> (sh_we && !mn_we));
  // R3: normal mode never touches the shadow bank
  assert_shadow_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !shadow_mode |-> !sh_we);
  // R5: register 31 reads zero on both ports
  assert_zero_read_a_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_a == ZERO_IDX) |-> (rd_data_a == '0));
  assert_zero_read_b_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_b == ZERO_IDX) |-> (rd_data_b == '0));
  // R6: a written register returns the new value in the next cycle
  assert_write_then_read_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != ZERO_IDX) |=>
      ((rd_idx_a != $past(wr_idx)) || (shadow_mode != $past(shadow_mode)) ||
       (rd_data_a == $past(wr_data))));
  // R9: the cycle after a reset edge reads zero
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (rd_data_a == '0 && rd_data_b == '0));
endmodule

// File: tb/test_priv_shadow_regfile.sv
`timescale 1ns/1ps
module test_priv_shadow_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shadow_mode = 1'b0;
  logic [4:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
  logic [63:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  // Reference state built from the requirements
  logic [63:0] m_main [32];
  logic [63:0] m_sh   [8];

  always #10 clk = ~clk;  // 50 MHz

  priv_shadow_regfile i_priv_shadow_regfile (
    .clk(clk), .rst(rst), .shadow_mode(shadow_mode),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic int sh_slot(input bit mode, input int idx);
    if (!mode) return -1;
    if (idx >= 8 && idx <= 14) return idx - 8;
    if (idx == 25) return 7;
    return -1;
  endfunction

  function automatic logic [63:0] expect_rd(input bit mode, input int idx);
    if (idx == 31) return 64'd0;
    if (sh_slot(mode, idx) >= 0) return m_sh[sh_slot(mode, idx)];
    return m_main[idx];
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 32; i++) m_main[i] = '0;
    for (int i = 0; i < 8; i++) m_sh[i] = '0;
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp,
                       input bit mode, input int idx);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: mode=%0b idx=%0d got %h expected %h", req, mode, idx, got, exp);
    end
  endtask

  task automatic do_write(input bit mode, input int idx, input logic [63:0] d);
    @(negedge clk);
    shadow_mode = mode; wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (idx != 31) begin
      if (sh_slot(mode, idx) >= 0) m_sh[sh_slot(mode, idx)] = d;
      else m_main[idx] = d;
    end
  endtask

  task automatic do_read(input string req, input bit mode, input int ia, input int ib);
    @(negedge clk);
    shadow_mode = mode; rd_idx_a = 5'(ia); rd_idx_b = 5'(ib);
    #1;
    check(req, rd_data_a, expect_rd(mode, ia), mode, ia);
    check(req, rd_data_b, expect_rd(mode, ib), mode, ib);
  endtask

  task automatic all_zero(input string req);
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        shadow_mode = m[0]; rd_idx_a = 5'(i); rd_idx_b = 5'(31 - i);
        #1;
        check(req, rd_data_a, 64'd0, m[0], i);
        check(req, rd_data_b, 64'd0, m[0], 31 - i);
      end
  endtask

  task automatic t_reset_state();  // R9
    all_zero("R9 reset state");
  endtask

  task automatic t_range_map();  // R1
    for (int i = 8; i <= 14; i++) do_write(1'b0, i, 64'hA000_0000_0000_0000 | 64'(i));
    for (int i = 8; i <= 14; i++) do_write(1'b1, i, 64'h5100_0000_0000_0000 | 64'(i * 3));
    for (int i = 8; i <= 14; i++) begin
      do_read("R1 shadow range", 1'b1, i, 22 - i);
      do_read("R1 main kept", 1'b0, i, i);
    end
  endtask

  task automatic t_lone_map();  // R2
    do_write(1'b0, 25, 64'h2525_0000_1111_0000);
    do_write(1'b1, 25, 64'hC0DE_2525_0000_7777);
    do_read("R2 lone shadow", 1'b1, 25, 14);
    do_read("R2 lone main kept", 1'b0, 25, 25);
  endtask

  task automatic t_normal_mode();  // R3
    for (int i = 8; i <= 14; i++) do_write(1'b0, i, 64'h3300_0000_0000_0000 | 64'(i));
    do_write(1'b0, 25, 64'h3333_2525_3333_2525);
    for (int i = 8; i <= 14; i++) do_read("R3 shadow untouched", 1'b1, i, 25);
    do_read("R3 main written", 1'b0, 9, 25);
  endtask

  task automatic t_unbanked();  // R4
    int regs[8] = '{0, 7, 15, 16, 24, 26, 29, 30};
    foreach (regs[k]) do_write(1'b1, regs[k], 64'hF00D_0000_0000_0000 | 64'(regs[k] * 17));
    foreach (regs[k]) do_read("R4 shared main", 1'b0, regs[k], regs[k]);
    foreach (regs[k]) do_read("R4 shared main", 1'b1, regs[k], regs[7 - k]);
  endtask

  task automatic t_zero_reg();  // R5
    do_write(1'b0, 31, 64'hFFFF_FFFF_FFFF_FFFF);
    do_write(1'b1, 31, 64'h1234_5678_9ABC_DEF0);
    do_read("R5 zero reg", 1'b0, 31, 31);
    do_read("R5 zero reg", 1'b1, 31, 30);
  endtask

  task automatic t_same_cycle();  // R6
    logic [63:0] old_v;
    old_v = expect_rd(1'b0, 5);
    @(negedge clk);
    shadow_mode = 1'b0; wr_en = 1'b1; wr_idx = 5'd5; wr_data = 64'hDEAD_BEEF_0505_0505;
    rd_idx_a = 5'd5; rd_idx_b = 5'd5;
    #1;
    check("R6 old value same cycle", rd_data_a, old_v, 1'b0, 5);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    m_main[5] = 64'hDEAD_BEEF_0505_0505;
    #1;
    check("R6 new value next cycle", rd_data_a, 64'hDEAD_BEEF_0505_0505, 1'b0, 5);
    check("R6 new value port b", rd_data_b, 64'hDEAD_BEEF_0505_0505, 1'b0, 5);
  endtask

  task automatic t_dual_port();  // R7
    do_read("R7 dual port", 1'b1, 12, 12);
    do_read("R7 dual port", 1'b1, 25, 3);
    do_read("R7 dual port", 1'b0, 12, 25);
    do_read("R7 dual port", 1'b1, 8, 14);
  endtask

  task automatic t_mode_switch();  // R8
    do_write(1'b1, 10, 64'h8888_0000_0000_1010);
    do_read("R8 switch to normal", 1'b0, 10, 10);
    do_read("R8 switch to shadow", 1'b1, 10, 10);
    do_write(1'b0, 10, 64'h8888_0000_0000_2020);
    do_write(1'b1, 10, 64'h8888_0000_0000_3030);
    do_read("R8 alternate writes", 1'b0, 10, 10);
    do_read("R8 alternate writes", 1'b1, 10, 10);
  endtask

  task automatic t_reset_clears();  // R9
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    model_clear();
    all_zero("R9 reset clears both banks");
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset_state();
    t_range_map();
    t_lone_map();
    t_normal_mode();
    t_unbanked();
    t_zero_reg();
    t_same_cycle();
    t_dual_port();
    t_mode_switch();
    t_reset_clears();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule